// File: doc/BRIEF.md
# Printer Port Register Block

This block is the register side of a byte-wide, PC-style printer port. A host bus reaches it through a 3-bit offset with separate read and write strobes. Behind that offset sit three registers: a data latch, a printer status register and a port control register. There are no real port pins. Instead the block contains a small model of an attached printer. Control writes and status reads move its busy and acknowledge bits through their handshake sequence.

Software prints a byte in three steps. It writes the data latch, pulses the strobe bit through the control register, and polls status. The block sends the latched byte to a character sink as a single-cycle pulse when strobe rises. It can also flag a level interrupt when strobe is driven low while interrupts are enabled. A direction bit in control decides what a data read returns: either the byte last written or an external input byte.

Reads are registered. The value appears on `rd_data` in the cycle after `rd_en` and holds until the next read. A read's side effects on status and on the interrupt take effect at the same clock edge.

Top module: `lpt_regblock`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x00, `irq` and `sink_valid` are 0. The data latch reads 0xFF, status reads 0xD9 and control reads 0xCC.
- R2: Only offsets 0 (data), 1 (status) and 2 (control) are implemented. A read at offsets 3 to 7 returns 0xFF. Writes to offset 1 or to offsets 3 to 7 change no register.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. The control bit positions are: direction at bit 5, interrupt enable at bit 4, select at bit 3, init at bit 2 and strobe at bit 0.
- R4: A control write with init=0 loads status with 0xD8. The status bit positions are: busy-complement at 7, ack at 6, paper-out at 5, online at 4, error-complement at 3 and timeout at 0.
- R5: A control write with init=1, select=1 and strobe=1 clears status bit 7. If the strobe bit stored before that write was 0, `sink_valid` pulses for exactly one cycle after the write, carrying the data latch on `sink_byte`. Otherwise no pulse occurs.
- R6: A control write with init=1, select=1 and strobe=0 sets the interrupt pending flag when the previously stored interrupt enable is 1. `irq` shows the flag from the cycle after the access.
- R7: A status read clears the pending flag, so `irq` is 0 from the cycle after the read.
- R8: A status read returns status as it was before the read. Then, if status bit 7 is 0 and the stored strobe is 0, the read steps the handshake. When ack (bit 6) is 1 it is cleared. When ack is 0, both ack and busy (bits 6 and 7) are set.
- R9: A data read returns the external input byte when control bit 5 is 1, and the data latch when it is 0.
- R10: `rd_data` changes only in the cycle after `rd_en`. Otherwise it holds its value.
- R11: A control write with init=1 and select=0 leaves status, the pending flag and the sink untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| ext_din | input | 8 | External byte returned by data reads when direction is 1 |
| sink_valid | output | 1 | One-cycle pulse: a byte is printed |
| sink_byte | output | 8 | Printed byte |
| irq | output | 1 | Level interrupt |

## Verification
The handshake is driven with control values that differ in one field at a time: init low, select low, strobe high and strobe low, each with interrupt enable on or off. Each pair separates one branch of the control-write decision. Strobe is written high twice in a row, once after low and once after high, which shows that a byte is printed only on the rising strobe. A run of status reads with strobe low walks the ack and busy bits through their full cycle, 0x58 to 0x18 to 0xD8. It shows that reads with strobe high, or with busy set, do not step the handshake. Data reads are issued with the direction bit in both states against a distinct external byte, and two different printed bytes confirm that the sink carries the current latch.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef logic [7:0] byte_t;

  localparam int NREG = 3;
  localparam int OFF_DATA = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_CTRL = 2;

  // control bit positions
  localparam int C_STB = 0;
  localparam int C_INI = 2;
  localparam int C_SEL = 3;
  localparam int C_IEN = 4;
  localparam int C_DIR = 5;

  // status bit positions
  localparam int S_ACK  = 6;
  localparam int S_BUSY = 7;

  localparam byte_t CTRL_FORCE = 8'hC0;
  localparam byte_t CTRL_RST   = 8'hCC;
  localparam byte_t STAT_RST   = 8'hD9;
  localparam byte_t STAT_INIT  = 8'hD8;
  localparam byte_t DATA_RST   = 8'hFF;
  localparam byte_t FILL_BYTE  = 8'hFF;
endpackage

// File: rtl/lpt_decode.sv
module lpt_decode #(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  output logic                  wr_data_sel,
  output logic                  wr_ctrl_sel,
  output logic [lpt_pkg::NREG-1:0] rd_sel,
  output logic                  rd_other
);
  import lpt_pkg::*;

  for (genvar g = 0; g < NREG; g++) begin : g_rsel
    assign rd_sel[g] = rd_en && (addr == ADDR_W'(g));
  end

  assign rd_other    = rd_en && (addr >= ADDR_W'(NREG));
  assign wr_data_sel = wr_en && (addr == ADDR_W'(OFF_DATA));
  assign wr_ctrl_sel = wr_en && (addr == ADDR_W'(OFF_CTRL));
endmodule

// File: rtl/lpt_data_reg.sv
module lpt_data_reg (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sel,
  input  lpt_pkg::byte_t wdata,
  output lpt_pkg::byte_t data_q
);
  import lpt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)         data_q <= DATA_RST;
    else if (wr_sel) data_q <= wdata;
  end

  // R2: latch moves only on a data-offset write
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(data_q));
endmodule

// File: rtl/lpt_handshake.sv
module lpt_handshake (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctrl_wr,
  input  logic           stat_rd,
  input  lpt_pkg::byte_t wdata,
  input  lpt_pkg::byte_t data_q,
  output lpt_pkg::byte_t ctrl_q,
  output lpt_pkg::byte_t stat_q,
  output logic           pend_q,
  output logic           sink_v,
  output lpt_pkg::byte_t sink_b
);
  import lpt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      stat_q <= STAT_RST;
      pend_q <= 1'b0;
      sink_v <= 1'b0;
      sink_b <= DATA_RST;
    end else begin
      sink_v <= 1'b0;
      if (ctrl_wr) begin
        ctrl_q <= wdata | CTRL_FORCE;
        if (!wdata[C_INI]) begin
          stat_q <= STAT_INIT;
        end else if (wdata[C_SEL]) begin
          if (wdata[C_STB]) begin
            stat_q[S_BUSY] <= 1'b0;
            if (!ctrl_q[C_STB]) begin
              sink_v <= 1'b1;
              sink_b <= data_q;
            end
          end else if (ctrl_q[C_IEN]) begin
            pend_q <= 1'b1;
          end
        end
      end else if (stat_rd) begin
        pend_q <= 1'b0;
        if (!stat_q[S_BUSY] && !ctrl_q[C_STB]) begin
          if (stat_q[S_ACK]) begin
            stat_q[S_ACK] <= 1'b0;
          end else begin
            stat_q[S_ACK]  <= 1'b1;
            stat_q[S_BUSY] <= 1'b1;
          end
        end
      end
    end
  end

  p_init_load_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wdata[C_INI]) |=> (stat_q == STAT_INIT));

  p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[C_INI] && wdata[C_SEL] && wdata[C_STB]) |=> !stat_q[S_BUSY]);

  p_emit_r5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[C_INI] && wdata[C_SEL] && wdata[C_STB] && !ctrl_q[C_STB])
      |=> (sink_v && sink_b == $past(data_q)));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    sink_v |=> !sink_v);

  p_irq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[C_INI] && wdata[C_SEL] && !wdata[C_STB] && ctrl_q[C_IEN]) |=> pend_q);

  p_irq_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !ctrl_wr) |=> !pend_q);

  p_sel_low_r11: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[C_INI] && !wdata[C_SEL])
      |=> ($stable(stat_q) && $stable(pend_q) && !sink_v));
endmodule

// File: rtl/lpt_rd_mux.sv
module lpt_rd_mux (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [lpt_pkg::NREG-1:0] rd_sel,
  input  logic                     rd_other,
  input  lpt_pkg::byte_t           data_q,
  input  lpt_pkg::byte_t           ext_din,
  input  lpt_pkg::byte_t           stat_q,
  input  lpt_pkg::byte_t           ctrl_q,
  output lpt_pkg::byte_t           rd_q
);
  import lpt_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 8'h00;
    end else if (rd_sel[OFF_DATA]) begin
      rd_q <= ctrl_q[C_DIR] ? ext_din : data_q;
    end else if (rd_sel[OFF_STAT]) begin
      rd_q <= stat_q;
    end else if (rd_sel[OFF_CTRL]) begin
      rd_q <= ctrl_q;
    end else if (rd_other) begin
      rd_q <= FILL_BYTE;
    end
  end

  p_unimpl_fill_r2: assert property (@(posedge clk) disable iff (rst)
    rd_other |=> (rd_q == FILL_BYTE));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == '0 && !rd_other) |=> $stable(rd_q));
endmodule

// File: rtl/lpt_regblock.sv
module lpt_regblock #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic [7:0]        ext_din,
  output logic              sink_valid,
  output logic [7:0]        sink_byte,
  output logic              irq
);
  import lpt_pkg::*;

  logic             wr_data_sel, wr_ctrl_sel, rd_other;
  logic [NREG-1:0]  rd_sel;
  byte_t            data_q, ctrl_q, stat_q;
  logic             pend_q;

  lpt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data_sel(wr_data_sel), .wr_ctrl_sel(wr_ctrl_sel),
    .rd_sel(rd_sel), .rd_other(rd_other)
  );

  lpt_data_reg u_data (
    .clk(clk), .rst(rst), .wr_sel(wr_data_sel), .wdata(wr_data), .data_q(data_q)
  );

  lpt_handshake u_hs (
    .clk(clk), .rst(rst), .ctrl_wr(wr_ctrl_sel), .stat_rd(rd_sel[OFF_STAT]),
    .wdata(wr_data), .data_q(data_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .pend_q(pend_q), .sink_v(sink_valid), .sink_b(sink_byte)
  );

  lpt_rd_mux u_mux (
    .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_other(rd_other),
    .data_q(data_q), .ext_din(ext_din), .stat_q(stat_q), .ctrl_q(ctrl_q),
    .rd_q(rd_data)
  );

  assign irq = pend_q;

  // R6/R7: interrupt only rises on a control write
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(wr_en && addr == ADDR_W'(OFF_CTRL)));
endmodule

// File: tb/lpt_regblock_tb.sv
module lpt_regblock_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wr_data, rd_data, ext_din, sink_byte;
  logic       sink_valid, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic       cap_sv;
  logic [7:0] cap_sb;
  logic       cap_irq;

  always #5 clk = ~clk;

  lpt_regblock #(.ADDR_W(3)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ext_din(ext_din),
    .sink_valid(sink_valid), .sink_byte(sink_byte), .irq(irq)
  );

  // {op(1=write), addr[2:0], data[7:0], expect[7:0], sink_expected, irq_expected}
  localparam int NV = 36;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {1'b0, 3'd2, 8'h00, 8'hCC, 1'b0, 1'b0},  // 0  control reset
    {1'b0, 3'd1, 8'h00, 8'hD9, 1'b0, 1'b0},  // 1  status reset, busy set -> no step
    {1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 1'b0},  // 2  data reset
    {1'b0, 3'd5, 8'h00, 8'hFF, 1'b0, 1'b0},  // 3  R2 unimplemented
    {1'b0, 3'd7, 8'h00, 8'hFF, 1'b0, 1'b0},  // 4
    {1'b1, 3'd0, 8'h41, 8'h00, 1'b0, 1'b0},  // 5  write latch
    {1'b0, 3'd0, 8'h00, 8'h41, 1'b0, 1'b0},  // 6
    {1'b1, 3'd2, 8'h00, 8'h00, 1'b0, 1'b0},  // 7  R4 init low
    {1'b0, 3'd2, 8'h00, 8'hC0, 1'b0, 1'b0},  // 8  R3 forced bits
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0},  // 9  R4 status
    {1'b1, 3'd2, 8'h0D, 8'h41, 1'b1, 1'b0},  // 10 R5 strobe rise -> print
    {1'b0, 3'd1, 8'h00, 8'h58, 1'b0, 1'b0},  // 11 strobe high -> no step
    {1'b1, 3'd2, 8'h0C, 8'h00, 1'b0, 1'b0},  // 12 strobe low, enable was 0
    {1'b0, 3'd1, 8'h00, 8'h58, 1'b0, 1'b0},  // 13 R8 step: ack clears
    {1'b0, 3'd1, 8'h00, 8'h18, 1'b0, 1'b0},  // 14 R8 step: ack+busy set
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0},  // 15 busy set -> stable
    {1'b1, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0},  // 16 R2 status write ignored
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0},  // 17
    {1'b1, 3'd2, 8'h3C, 8'h00, 1'b0, 1'b0},  // 18 dir=1, enable=1
    {1'b0, 3'd2, 8'h00, 8'hFC, 1'b0, 1'b0},  // 19
    {1'b0, 3'd0, 8'h00, 8'h5A, 1'b0, 1'b0},  // 20 R9 external byte
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b0, 1'b1},  // 21 R6 irq pending
    {1'b0, 3'd0, 8'h00, 8'h41, 1'b0, 1'b1},  // 22 R9 latch, irq held
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0},  // 23 R7 clear
    {1'b1, 3'd2, 8'h15, 8'h00, 1'b0, 1'b0},  // 24 R11 select low, strobe high
    {1'b1, 3'd2, 8'h14, 8'h00, 1'b0, 1'b0},  // 25 R11 select low, strobe low
    {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0, 1'b0},  // 26 R11 status untouched
    {1'b1, 3'd2, 8'h1D, 8'h41, 1'b1, 1'b0},  // 27 R5 print
    {1'b1, 3'd2, 8'h1D, 8'h00, 1'b0, 1'b0},  // 28 R5 strobe already high
    {1'b1, 3'd0, 8'h7E, 8'h00, 1'b0, 1'b0},  // 29
    {1'b1, 3'd2, 8'h1C, 8'h00, 1'b0, 1'b1},  // 30 R6
    {1'b1, 3'd2, 8'h1D, 8'h7E, 1'b1, 1'b1},  // 31 R5 new byte, irq held
    {1'b0, 3'd1, 8'h00, 8'h58, 1'b0, 1'b0},  // 32 R7
    {1'b1, 3'd3, 8'hAA, 8'h00, 1'b0, 1'b0},  // 33 R2 write to unused offset
    {1'b0, 3'd0, 8'h00, 8'h7E, 1'b0, 1'b0},  // 34
    {1'b0, 3'd2, 8'h00, 8'hDD, 1'b0, 1'b0}   // 35 R3
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    cap_sv = sink_valid; cap_sb = sink_byte; cap_irq = irq;
  endtask

  task automatic do_read(input logic [2:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    cap_irq = irq;
  endtask

  function automatic string rd_tag(input logic [2:0] a);
    if (a == 3'd0) return "R9 data read";
    if (a == 3'd1) return "R4/R8/R11 status read";
    if (a == 3'd2) return "R3 control read";
    return "R2 unused offset read";
  endfunction

  initial begin
    rst = 1'b1; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0; ext_din = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    chk("R1 sink_valid in reset", {7'd0, sink_valid}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[21]) begin
        do_write(v[20:18], v[17:10]);
        chk("R5 sink pulse", {7'd0, cap_sv}, {7'd0, v[1]});
        if (v[1]) chk("R5 sink byte", cap_sb, v[9:2]);
      end else begin
        do_read(v[20:18]);
        chk(rd_tag(v[20:18]), rd_data, v[9:2]);
      end
      chk("R6/R7 irq level", {7'd0, cap_irq}, {7'd0, v[0]});
    end

    // R5: pulse lasts one cycle only
    @(negedge clk);
    chk("R5 pulse gone", {7'd0, sink_valid}, 8'h00);

    // R10: rd_data holds without a read, even across a write
    do_read(3'd2);
    chk("R10 read value", rd_data, 8'hDD);
    repeat (3) @(negedge clk);
    chk("R10 idle hold", rd_data, 8'hDD);
    do_write(3'd0, 8'h33);
    chk("R10 hold over write", rd_data, 8'hDD);

    // R1: reset mid-run clears pending interrupt and registers
    do_write(3'd2, 8'h1C);
    chk("R6 irq before reset", {7'd0, cap_irq}, 8'h01);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 irq cleared", {7'd0, irq}, 8'h00);
    rst = 1'b0;
    do_read(3'd2); chk("R1 control after reset", rd_data, 8'hCC);
    do_read(3'd1); chk("R1 status after reset", rd_data, 8'hD9);
    do_read(3'd0); chk("R1 data after reset", rd_data, 8'hFF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule